// File: doc/BRIEF.md
# Segmented Address Translation Checker

This unit converts a segment selector and a 32-bit offset into a flat linear address. Alongside the address it reports how many bytes can be reached from it, or an error status instead. The caller supplies several inputs:

- a mode flag that picks the legacy 16-bit scheme (real or virtual-8086) or protected translation;
- the 64-bit descriptor that the selector names, already fetched;
- the byte limits of the global and local descriptor tables;
- a flag that waives the bound check on the global table.

The unit checks the selector against its table, whether the segment is present, the segment class and the segment limit. All results are registered. A request strobe captures one translation. One cycle later a valid strobe presents it, and the results stay in place until the next request. Privilege levels, paging and fetching descriptors from memory are outside the block.

Top module: `segxl_top`

## Requirements
- R1: `out_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. `flat_addr`, `remain` and `status` change only in the cycle after a request. Between requests they hold their values.
- R2: With `legacy_mode` high, the address is (offset AND 0xFFFF) plus (selector times 16). `remain` is 0x10000 minus (offset AND 0xFFFF) and `status` is 0. No other check is made.
- R3: Selector bit 2 set selects the local table limit; clear selects the global one. If (selector AND 0xFFF8) is greater than or equal to that limit, `status` is 1. For the global table this check is skipped while `skip_gdt_bound` is high. The check has priority over every other protected-mode check.
- R4: The segment base is descriptor bits 63:56 as base bits 31:24, descriptor bits 39:32 as base bits 23:16, and descriptor bits 31:16 as base bits 15:0. The flat address is base plus offset.
- R5: The raw limit is descriptor bits 51:48 above descriptor bits 15:0. When the granularity bit (descriptor bit 55) is set, the effective limit is the raw limit shifted left by 12, ORed with 0xFFF.
- R6: A descriptor with bit 47 (present) clear gives `status` 3. This takes priority over the class and limit checks.
- R7: Descriptor bit 44 set with type (bits 43:40) 8 to 15 (code), or 0 to 3 (ordinary data), is a flat-class segment. An offset above the limit gives `status` 2. Otherwise `remain` is limit minus offset plus 1.
- R8: Descriptor bit 44 set with type 4 to 7 is an expand-down segment. An offset at or below the limit gives `status` 2. With granularity clear, an offset above 0xFFFF also gives `status` 2. Otherwise `remain` is 0xFFFF (granularity clear) or 0xFFFFFFFF (granularity set) minus offset plus 1.
- R9: Descriptor bit 44 clear with type 1 to 7, 9, 11, 12, 14 or 15 is a system segment. It uses the R7 limit check, and `remain` is 2^32 minus the flat address. Types 0, 8, 10 and 13 give `status` 1.
- R10: `status` codes are 0 ok, 1 invalid selector, 2 out of bounds and 3 not present. On any nonzero status, `flat_addr` and `remain` are 0. On status 0, `remain` lies between 1 and 2^32.
- R11: The address addition wraps modulo 2^32.
- R12: After reset, `out_valid`, `flat_addr`, `remain` and `status` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Capture a translation this cycle |
| legacy_mode | input | 1 | Real or virtual-8086 addressing |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Offset within the segment |
| desc | input | 64 | Descriptor named by the selector |
| gdt_limit | input | 17 | Global table byte limit |
| ldt_limit | input | 17 | Local table byte limit |
| skip_gdt_bound | input | 1 | Waive the global table bound check |
| out_valid | output | 1 | Result strobe |
| flat_addr | output | 32 | Linear address |
| remain | output | 33 | Bytes reachable from the address |
| status | output | 3 | Result code |

## Verification
Every result passes through exactly one register stage. Address, byte count and status are all due in the cycle after the request, together with the strobe. The bench applies inputs on the falling edge and drops the request after one cycle. It compares all three results on the next falling edge, so they are taken half a cycle after the capturing edge. After a request, the bench changes every input with the request low and samples again one cycle later. At that point the outputs must be unchanged and the strobe must be low.

// File: rtl/segxl_pkg.sv
package segxl_pkg;

   typedef enum logic [2:0] {
      SX_OK      = 3'd0,
      SX_BAD_SEL = 3'd1,
      SX_OOB     = 3'd2,
      SX_ABSENT  = 3'd3
   } sx_status_e;

   typedef enum logic [1:0] {
      CLS_FLAT = 2'd0,
      CLS_DOWN = 2'd1,
      CLS_SYS  = 2'd2,
      CLS_BAD  = 2'd3
   } sx_class_e;

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] limit;
      logic        present;
      logic        gran;
      logic        user_seg;
      logic [3:0]  kind;
   } sx_fields_t;

   localparam int unsigned SX_AW = 32;
   localparam int unsigned SX_RW = SX_AW + 1;

endpackage

// File: rtl/segxl_field_unpack.sv
module segxl_field_unpack
   import segxl_pkg::*;
#(
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic [63:0] desc,
   output sx_fields_t  fields
);
   localparam int unsigned RAW_LIM_W = 20;

   generate
      if (PAGE_SHIFT + RAW_LIM_W != SX_AW) begin : g_bad_page
         $error("segxl_field_unpack: PAGE_SHIFT must fill the address width");
      end
   endgenerate

   logic [RAW_LIM_W-1:0] raw_lim;
   logic                 unused_bits;

   assign raw_lim     = {desc[51:48], desc[15:0]};
   assign unused_bits = ^{desc[54:52], desc[46:45]};

   always_comb begin
      fields.base     = {desc[63:56], desc[39:32], desc[31:16]};
      fields.present  = desc[47];
      fields.gran     = desc[55];
      fields.user_seg = desc[44];
      fields.kind     = desc[43:40];
      if (desc[55])
         fields.limit = {raw_lim, {PAGE_SHIFT{1'b1}}};
      else
         fields.limit = {{PAGE_SHIFT{1'b0}}, raw_lim};
   end

endmodule

// File: rtl/segxl_table_guard.sv
module segxl_table_guard #(
   parameter int unsigned SEL_W       = 16,
   parameter int unsigned TLIM_W      = 17,
   parameter bit          SKIP_ENABLE = 1'b1
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [TLIM_W-1:0] gdt_limit,
   input  logic [TLIM_W-1:0] ldt_limit,
   input  logic              skip_gdt_bound,
   output logic              bad_sel
);
   localparam int unsigned PAD_W = TLIM_W - SEL_W;

   generate
      if (SEL_W < 3 || SEL_W > 16) begin : g_bad_sel_w
         $error("segxl_table_guard: SEL_W out of range");
      end
      if (TLIM_W <= SEL_W) begin : g_bad_tlim_w
         $error("segxl_table_guard: TLIM_W must exceed SEL_W");
      end
   endgenerate

   logic [TLIM_W-1:0] byte_off;
   logic [TLIM_W-1:0] tbl_lim;
   logic              use_local;
   logic              over;
   logic              waive;
   logic              unused_rpl;

   assign use_local  = sel[2];
   assign unused_rpl = ^sel[1:0];
   assign byte_off   = {{PAD_W{1'b0}}, sel[SEL_W-1:3], 3'b000};
   assign tbl_lim    = use_local ? ldt_limit : gdt_limit;
   assign over       = (byte_off >= tbl_lim);

   generate
      if (SKIP_ENABLE) begin : g_skip
         assign waive = skip_gdt_bound & ~use_local;
      end else begin : g_noskip
         logic unused_skip;
         assign unused_skip = skip_gdt_bound;
         assign waive       = 1'b0;
      end
   endgenerate

   assign bad_sel = over & ~waive;

endmodule

// File: rtl/segxl_seg_eval.sv
module segxl_seg_eval
   import segxl_pkg::*;
#(
   parameter logic [15:0] SYS_TYPE_MASK = 16'hDAFE
) (
   input  logic [31:0] offset,
   input  sx_fields_t  fields,
   input  logic        bad_sel,
   output logic [31:0] flat,
   output logic [32:0] remain,
   output sx_status_e  status
);
   localparam logic [32:0] FULL_SPAN = 33'h1_0000_0000;
   localparam logic [32:0] TOP_SMALL = 33'h0_0000_FFFF;
   localparam logic [32:0] TOP_BIG   = 33'h0_FFFF_FFFF;

   logic [15:0] sys_ok;
   genvar t;
   generate
      for (t = 0; t < 16; t++) begin : g_sys
         assign sys_ok[t] = SYS_TYPE_MASK[t];
      end
   endgenerate

   sx_class_e   cls;
   logic [31:0] sum;
   logic [32:0] off_x;
   logic [32:0] lim_x;

   assign sum   = fields.base + offset;
   assign off_x = {1'b0, offset};
   assign lim_x = {1'b0, fields.limit};

   always_comb begin
      if (fields.user_seg) begin
         if (!fields.kind[3] && fields.kind[2]) cls = CLS_DOWN;
         else                                   cls = CLS_FLAT;
      end else begin
         cls = sys_ok[fields.kind] ? CLS_SYS : CLS_BAD;
      end
   end

   always_comb begin
      flat   = '0;
      remain = '0;
      status = SX_OK;
      if (bad_sel) begin
         status = SX_BAD_SEL;
      end else if (!fields.present) begin
         status = SX_ABSENT;
      end else begin
         unique case (cls)
            CLS_FLAT: begin
               if (off_x > lim_x) status = SX_OOB;
               else begin
                  flat   = sum;
                  remain = lim_x - off_x + 33'd1;
               end
            end
            CLS_DOWN: begin
               if ((!fields.gran && off_x > TOP_SMALL) || off_x <= lim_x)
                  status = SX_OOB;
               else begin
                  flat   = sum;
                  remain = (fields.gran ? TOP_BIG : TOP_SMALL) - off_x + 33'd1;
               end
            end
            CLS_SYS: begin
               if (off_x > lim_x) status = SX_OOB;
               else begin
                  flat   = sum;
                  remain = FULL_SPAN - {1'b0, sum};
               end
            end
            default: status = SX_BAD_SEL;
         endcase
      end
   end

endmodule

// File: rtl/segxl_top.sv
module segxl_top
   import segxl_pkg::*;
#(
   parameter int unsigned SEL_W         = 16,
   parameter int unsigned TLIM_W        = 17,
   parameter int unsigned LEGACY_SHIFT  = 4,
   parameter int unsigned PAGE_SHIFT    = 12,
   parameter bit          SKIP_ENABLE   = 1'b1,
   parameter logic [15:0] SYS_TYPE_MASK = 16'hDAFE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              legacy_mode,
   input  logic [SEL_W-1:0]  sel,
   input  logic [31:0]       offset,
   input  logic [63:0]       desc,
   input  logic [TLIM_W-1:0] gdt_limit,
   input  logic [TLIM_W-1:0] ldt_limit,
   input  logic              skip_gdt_bound,
   output logic              out_valid,
   output logic [31:0]       flat_addr,
   output logic [32:0]       remain,
   output logic [2:0]        status
);
   localparam int unsigned LEG_W = 16;

   generate
      if (LEGACY_SHIFT + SEL_W > SX_AW) begin : g_bad_shift
         $error("segxl_top: legacy shift overflows the address");
      end
   endgenerate

   sx_fields_t  fields;
   logic        tbl_bad;
   logic [31:0] pm_flat;
   logic [32:0] pm_remain;
   sx_status_e  pm_status;

   segxl_field_unpack #(.PAGE_SHIFT(PAGE_SHIFT)) unpack_i (
      .desc   (desc),
      .fields (fields)
   );

   segxl_table_guard #(
      .SEL_W(SEL_W), .TLIM_W(TLIM_W), .SKIP_ENABLE(SKIP_ENABLE)
   ) guard_i (
      .sel            (sel),
      .gdt_limit      (gdt_limit),
      .ldt_limit      (ldt_limit),
      .skip_gdt_bound (skip_gdt_bound),
      .bad_sel        (tbl_bad)
   );

   segxl_seg_eval #(.SYS_TYPE_MASK(SYS_TYPE_MASK)) eval_i (
      .offset  (offset),
      .fields  (fields),
      .bad_sel (tbl_bad),
      .flat    (pm_flat),
      .remain  (pm_remain),
      .status  (pm_status)
   );

   logic [31:0] lg_off;
   logic [31:0] lg_seg;
   logic [31:0] lg_flat;
   logic [32:0] lg_remain;

   assign lg_off    = {{(SX_AW-LEG_W){1'b0}}, offset[LEG_W-1:0]};
   assign lg_seg    = {{(SX_AW-SEL_W){1'b0}}, sel} << LEGACY_SHIFT;
   assign lg_flat   = lg_off + lg_seg;
   assign lg_remain = 33'h1_0000 - {1'b0, lg_off};

   logic [31:0] nx_flat;
   logic [32:0] nx_remain;
   sx_status_e  nx_status;

   always_comb begin
      if (legacy_mode) begin
         nx_flat   = lg_flat;
         nx_remain = lg_remain;
         nx_status = SX_OK;
      end else begin
         nx_flat   = pm_flat;
         nx_remain = pm_remain;
         nx_status = pm_status;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         flat_addr <= '0;
         remain    <= '0;
         status    <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid) begin
            flat_addr <= nx_flat;
            remain    <= nx_remain;
            status    <= nx_status;
         end
      end
   end

   // R1: strobe follows the request by one cycle; results hold between requests
   a_r1_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && $stable(flat_addr) && $stable(remain) && $stable(status)));

   // R2: legacy path never fails and counts to the 64 KiB edge
   a_r2_legacy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && legacy_mode) |=>
         (status == 3'd0 && remain == (33'h1_0000 - {17'b0, $past(offset[15:0])})));

   // R3: a table bound failure wins over every other protected check
   a_r3_bound_first: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !legacy_mode && tbl_bad) |=> status == 3'd1);

   // R6: absent descriptor reported ahead of class and limit
   a_r6_absent: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !legacy_mode && !tbl_bad && !fields.present) |=> status == 3'd3);

   // R10: failures carry no address or count; successes carry a sane count
   a_r10_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && status != 3'd0) |-> (flat_addr == 32'd0 && remain == 33'd0));
   a_r10_ok_range: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && status == 3'd0) |-> (remain != 33'd0 && remain <= 33'h1_0000_0000));
   a_r10_code: assert property (@(posedge clk) disable iff (!rst_n)
      status <= 3'd3);

endmodule

// File: tb/segxl_top_tb_top.sv
`timescale 1ns/1ps
module segxl_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        legacy_mode = 1'b0;
   logic [15:0] sel = '0;
   logic [31:0] offset = '0;
   logic [63:0] desc = '0;
   logic [16:0] gdt_limit = '0;
   logic [16:0] ldt_limit = '0;
   logic        skip_gdt_bound = 1'b0;
   logic        out_valid;
   logic [31:0] flat_addr;
   logic [32:0] remain;
   logic [2:0]  status;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   segxl_top dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .legacy_mode(legacy_mode),
      .sel(sel), .offset(offset), .desc(desc), .gdt_limit(gdt_limit),
      .ldt_limit(ldt_limit), .skip_gdt_bound(skip_gdt_bound),
      .out_valid(out_valid), .flat_addr(flat_addr), .remain(remain), .status(status)
   );

   function automatic logic [63:0] mkdesc(input logic [31:0] base, input logic [19:0] lim,
                                          input logic [3:0] kind, input bit user,
                                          input bit pres, input bit gran);
      logic [63:0] d;
      d = '0;
      d[15:0]  = lim[15:0];
      d[51:48] = lim[19:16];
      d[31:16] = base[15:0];
      d[39:32] = base[23:16];
      d[63:56] = base[31:24];
      d[43:40] = kind;
      d[44]    = user;
      d[47]    = pres;
      d[55]    = gran;
      return d;
   endfunction

   task automatic expect_of(output logic [31:0] ea, output logic [32:0] er,
                            output logic [2:0] es, output string tag);
      longint unsigned b, l, o, fl;
      logic [16:0] tl;
      ea = '0; er = '0; es = 3'd0;
      o = longint'(offset);
      if (legacy_mode) begin
         tag = "R2";
         ea  = 32'(longint'(offset[15:0]) + longint'(sel) * 16);
         er  = 33'(65536 - longint'(offset[15:0]));
         return;
      end
      tl = sel[2] ? ldt_limit : gdt_limit;
      if ((sel[2] || !skip_gdt_bound) && ({1'b0, sel & 16'hFFF8} >= tl)) begin
         tag = "R3"; es = 3'd1; return;
      end
      if (!desc[47]) begin tag = "R6"; es = 3'd3; return; end
      b  = longint'({desc[63:56], desc[39:32], desc[31:16]});
      l  = longint'({desc[51:48], desc[15:0]});
      if (desc[55]) l = l * 4096 + 4095;
      fl = (b + o) % 64'h1_0000_0000;
      if (desc[44]) begin
         if (desc[43:40] >= 4 && desc[43:40] <= 7) begin
            tag = "R8";
            if (o <= l || (!desc[55] && o > 65535)) begin es = 3'd2; return; end
            ea = 32'(fl);
            er = 33'((desc[55] ? 64'hFFFF_FFFF : 64'hFFFF) - o + 1);
         end else begin
            tag = "R7";
            if (o > l) begin es = 3'd2; return; end
            ea = 32'(fl);
            er = 33'(l - o + 1);
         end
      end else begin
         tag = "R9";
         if (desc[43:40] == 0 || desc[43:40] == 8 || desc[43:40] == 10 || desc[43:40] == 13) begin
            es = 3'd1; return;
         end
         if (o > l) begin es = 3'd2; return; end
         ea = 32'(fl);
         er = 33'(64'h1_0000_0000 - fl);
      end
   endtask

   task automatic issue_and_check(input string extra);
      logic [31:0] ea; logic [32:0] er; logic [2:0] es; string tag;
      @(negedge clk);
      req_valid = 1'b1;
      expect_of(ea, er, es, tag);
      @(negedge clk);
      req_valid = 1'b0;
      checks++;
      if (out_valid !== 1'b1 || flat_addr !== ea || remain !== er || status !== es) begin
         errors++;
         $display("FAIL %s%s: valid=%0b addr=%h rem=%h st=%0d expected valid=1 addr=%h rem=%h st=%0d",
                  tag, extra, out_valid, flat_addr, remain, status, ea, er, es);
      end
   endtask

   task automatic hold_check();
      logic [31:0] fa; logic [32:0] rm; logic [2:0] st;
      fa = flat_addr; rm = remain; st = status;
      sel = ~sel; offset = ~offset; desc = ~desc; legacy_mode = ~legacy_mode;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || flat_addr !== fa || remain !== rm || status !== st) begin
         errors++;
         $display("FAIL R1 hold: valid=%0b addr=%h rem=%h st=%0d expected valid=0 addr=%h rem=%h st=%0d",
                  out_valid, flat_addr, remain, status, fa, rm, st);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: reset state
      checks++;
      if (out_valid !== 1'b0 || flat_addr !== '0 || remain !== '0 || status !== '0) begin
         errors++;
         $display("FAIL R12 reset: valid=%0b addr=%h rem=%h st=%0d expected all 0",
                  out_valid, flat_addr, remain, status);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2 legacy sweep (R11 wrap not reachable here; sums stay below 2^21)
      legacy_mode = 1'b1;
      gdt_limit = 17'h0; ldt_limit = 17'h0;
      foreach (int_sel_list[i]) begin
         for (int k = 0; k < 5; k++) begin
            sel = int_sel_list[i];
            offset = (k == 0) ? 32'h0 : (k == 1) ? 32'h1 : (k == 2) ? 32'hFFFF :
                     (k == 3) ? 32'h1234_5678 : 32'hFFFF_0000;
            desc = 64'h0;
            issue_and_check(" legacy");
         end
      end
      hold_check();

      // R4 R5 R6 R7 R8 R9 R10 R11: class sweep
      legacy_mode = 1'b0;
      gdt_limit = 17'h1_0000; ldt_limit = 17'h1_0000; skip_gdt_bound = 1'b0;
      for (int u = 0; u < 2; u++)
         for (int ty = 0; ty < 16; ty++)
            for (int g = 0; g < 2; g++)
               for (int p = 0; p < 2; p++)
                  for (int k = 0; k < 6; k++) begin
                     logic [31:0] lim;
                     lim = g ? 32'h0123_4FFF : 32'h0000_1234;
                     sel = (ty[0]) ? 16'h0014 : 16'h0010;
                     desc = mkdesc(32'h89AB_CDEF, 20'h01234, 4'(ty), u[0], p[0], g[0]);
                     offset = (k == 0) ? 32'h0 : (k == 1) ? lim : (k == 2) ? lim + 1 :
                              (k == 3) ? 32'hFFFF : (k == 4) ? 32'h1_0000 : 32'hFFFF_FFFF;
                     issue_and_check(" class");
                  end
      hold_check();

      // R7 R10: full 4 GiB span
      legacy_mode = 1'b0;
      sel = 16'h0008;
      desc = mkdesc(32'h0, 20'hFFFFF, 4'h2, 1'b1, 1'b1, 1'b1);
      offset = 32'h0;
      issue_and_check(" full-span");
      // R8: expand-down with zero limit, granularity clear
      desc = mkdesc(32'h1000, 20'h0, 4'h6, 1'b1, 1'b1, 1'b0);
      offset = 32'h1;
      issue_and_check(" down-min");
      offset = 32'h0;
      issue_and_check(" down-zero");

      // R3 table bound sweep, including priority over absent descriptors
      gdt_limit = 17'h0020; ldt_limit = 17'h0018;
      for (int idx = 0; idx < 8; idx++)
         for (int ti = 0; ti < 2; ti++)
            for (int sk = 0; sk < 2; sk++)
               for (int p = 0; p < 2; p++) begin
                  sel = 16'((idx << 3) | (ti << 2) | 3);
                  skip_gdt_bound = sk[0];
                  desc = mkdesc(32'h0000_4000, 20'h00FFF, 4'h3, 1'b1, p[0], 1'b0);
                  offset = 32'h10;
                  issue_and_check(" bound");
               end
      skip_gdt_bound = 1'b0;
      // R3: high selector against the largest table limit
      gdt_limit = 17'h1_0000;
      sel = 16'hFFF8;
      issue_and_check(" top-sel");
      hold_check();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   logic [15:0] int_sel_list [3] = '{16'h0000, 16'h1234, 16'hFFFF};

endmodule